// File: doc/BRIEF.md
# Embedded video sync decoder

This block takes a stream of 8-bit video bytes, one byte on each cycle where the byte enable is high. It recovers line and field timing from control words carried inside the stream rather than from separate sync wires. A control word is a three-byte preamble followed by a status byte. The status byte holds the field flag F, the vertical blanking flag V, the horizontal blanking flag H, and four protection bits.

From these flags the decoder strobes each active pixel byte. It pulses at the start and at the end of each active line, and pulses again whenever the field changes. It also holds vertical-blank and field-id levels. A status byte whose protection bits or marker bit are wrong raises an error pulse and leaves the timing state alone. Downstream logic uses the strobe to capture pixels, and uses the pulses to step its line and field counters.

Top module: `vsd_decoder`

## Requirements
- R1: A control word is the byte sequence 0xFF, 0x00, 0x00 followed by a status byte. In the status byte, bit 7 is the marker (always 1), bit 6 is F, bit 5 is V, bit 4 is H and bits 3..0 are protection bits P3..P0. A run of 0xFF bytes restarts the preamble search.
- R2: The expected protection bits are P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H. If a status byte has the wrong protection bits or a zero marker bit, `sync_err` pulses for one cycle and the H, V and F state stays as it was.
- R3: A valid word with H=0 that arrives while H is 1 pulses `act_begin`. A valid word with H=1 that arrives while H is 0 pulses `act_end`. A word that does not change H produces neither pulse.
- R4: An enabled byte that arrives while H=0 and V=0 and is not a control byte gives `pix_stb` high for one cycle, with the byte on `pix_byte`. Both appear in the cycle after the byte is taken.
- R5: None of the four bytes of a control word is strobed as pixel data, even in the middle of active video. A 0xFF byte, or a 0x00 byte that extends a partial preamble, is not strobed either.
- R6: After the first valid word following reset, `vblank` takes V only from valid words with H=1. A V value carried in a valid word with H=0 has no effect.
- R7: `field_id` follows the F bit of each valid word (0 means field 1, 1 means field 2). `field_begin` pulses for one cycle exactly when `field_id` changes value.
- R8: On cycles where `byte_en` is low, no pulse or strobe is produced and no state changes.
- R9: Synchronous reset puts the block in blanking with `vblank`=1 and `field_id`=0, and clears all pulses. The first valid word after reset sets V whatever its H. No pixel is strobed before a word with H=0 has been decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_en | input | 1 | Qualifies `byte_in` on this cycle |
| byte_in | input | 8 | Incoming video byte |
| pix_stb | output | 1 | Active pixel byte strobe |
| pix_byte | output | 8 | Pixel byte that goes with `pix_stb` |
| act_begin | output | 1 | Start of active video pulse |
| act_end | output | 1 | End of active video pulse |
| field_begin | output | 1 | Field change pulse |
| vblank | output | 1 | Vertical blanking level |
| field_id | output | 1 | Current field, 0 = field 1, 1 = field 2 |
| sync_err | output | 1 | Protection or marker mismatch pulse |

## Verification
The bench builds the decoder only with its default 8-bit byte width. With that width, every one of the eight F/V/H status encodings and its protection bits can be written as a literal byte. The stream drives each kind of flag transition: V carried in a start word, V carried in an end word, F toggling in both directions, and a corrupted word while in blanking. Partial preambles are driven both inside active video and inside blanking. A mid-line reset is followed by a start word with V=1, which exercises acquisition of V after reset.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    localparam int VSD_DATA_W = 8;
    localparam int VSD_PROT_W = 4;

    typedef enum logic [1:0] {
        PRE_IDLE,
        PRE_ONES,
        PRE_ONES_Z,
        PRE_ONES_ZZ
    } pre_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } vsd_flags_t;

    typedef struct packed {
        logic       valid;
        logic       err;
        vsd_flags_t flags;
    } vsd_code_t;

    function automatic logic [VSD_PROT_W-1:0] vsd_prot(input vsd_flags_t fl);
        vsd_prot = {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction

endpackage

// File: rtl/vsd_preamble_seek.sv
module vsd_preamble_seek
    import vsd_pkg::*;
#(
    parameter int DATA_W = VSD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_en,
    input  logic [DATA_W-1:0] byte_in,
    output logic              status_hit,
    output logic              ctrl_byte
);
    localparam logic [DATA_W-1:0] ONES  = '1;
    localparam logic [DATA_W-1:0] ZEROS = '0;

    pre_state_e state_q, state_d;
    logic       is_ones, is_zero;

    always_comb begin
        is_ones    = (byte_in == ONES);
        is_zero    = (byte_in == ZEROS);
        status_hit = byte_en && (state_q == PRE_ONES_ZZ);
        ctrl_byte  = byte_en && (is_ones || (state_q == PRE_ONES_ZZ) ||
                     (is_zero && ((state_q == PRE_ONES) || (state_q == PRE_ONES_Z))));
        state_d    = state_q;
        if (byte_en) begin
            unique case (state_q)
                PRE_ONES:   state_d = is_zero ? PRE_ONES_Z  : (is_ones ? PRE_ONES : PRE_IDLE);
                PRE_ONES_Z: state_d = is_zero ? PRE_ONES_ZZ : (is_ones ? PRE_ONES : PRE_IDLE);
                default:    state_d = is_ones ? PRE_ONES : PRE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PRE_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/vsd_code_check.sv
module vsd_code_check
    import vsd_pkg::*;
#(
    parameter int DATA_W = VSD_DATA_W
) (
    input  logic              status_hit,
    input  logic [DATA_W-1:0] byte_in,
    output vsd_code_t         code
);
    localparam int MARK_B = DATA_W - 1;
    localparam int F_B    = DATA_W - 2;
    localparam int V_B    = DATA_W - 3;
    localparam int H_B    = DATA_W - 4;

    vsd_flags_t           fl;
    logic [VSD_PROT_W-1:0] want;
    logic                 good;

    always_comb begin
        fl.f   = byte_in[F_B];
        fl.v   = byte_in[V_B];
        fl.h   = byte_in[H_B];
        want   = vsd_prot(fl);
        good   = byte_in[MARK_B] && (byte_in[VSD_PROT_W-1:0] == want);
        code.flags = fl;
        code.valid = status_hit && good;
        code.err   = status_hit && !good;
    end
endmodule

// File: rtl/vsd_timing_track.sv
module vsd_timing_track
    import vsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      byte_en,
    input  vsd_code_t code,
    output logic      h_q,
    output logic      v_q,
    output logic      f_q,
    output logic      acq_q,
    output logic      begin_q,
    output logic      end_q,
    output logic      fchg_q,
    output logic      err_q
);
    logic take;

    always_comb take = byte_en && code.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q     <= 1'b1;
            v_q     <= 1'b1;
            f_q     <= 1'b0;
            acq_q   <= 1'b0;
            begin_q <= 1'b0;
            end_q   <= 1'b0;
            fchg_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            begin_q <= take && h_q && !code.flags.h;
            end_q   <= take && !h_q && code.flags.h;
            fchg_q  <= take && (code.flags.f != f_q);
            err_q   <= byte_en && code.err;
            if (take) begin
                h_q   <= code.flags.h;
                f_q   <= code.flags.f;
                acq_q <= 1'b1;
                if (!acq_q || code.flags.h) v_q <= code.flags.v;
            end
        end
    end
endmodule

// File: rtl/vsd_pixel_gate.sv
module vsd_pixel_gate
    import vsd_pkg::*;
#(
    parameter int DATA_W = VSD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_en,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ctrl_byte,
    input  logic              h_q,
    input  logic              v_q,
    output logic              stb_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            data_q <= '0;
        end else begin
            stb_q <= byte_en && !ctrl_byte && !h_q && !v_q;
            if (byte_en) data_q <= byte_in;
        end
    end
endmodule

// File: rtl/vsd_decoder.sv
module vsd_decoder
    import vsd_pkg::*;
#(
    parameter int DATA_W = VSD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_en,
    input  logic [DATA_W-1:0] byte_in,
    output logic              pix_stb,
    output logic [DATA_W-1:0] pix_byte,
    output logic              act_begin,
    output logic              act_end,
    output logic              field_begin,
    output logic              vblank,
    output logic              field_id,
    output logic              sync_err
);
    logic      status_hit, ctrl_byte;
    vsd_code_t code;
    logic      h_q, acquired;

    vsd_preamble_seek #(.DATA_W(DATA_W)) seek_i (
        .clk(clk), .rst(rst), .byte_en(byte_en), .byte_in(byte_in),
        .status_hit(status_hit), .ctrl_byte(ctrl_byte)
    );

    vsd_code_check #(.DATA_W(DATA_W)) check_i (
        .status_hit(status_hit), .byte_in(byte_in), .code(code)
    );

    vsd_timing_track track_i (
        .clk(clk), .rst(rst), .byte_en(byte_en), .code(code),
        .h_q(h_q), .v_q(vblank), .f_q(field_id), .acq_q(acquired),
        .begin_q(act_begin), .end_q(act_end), .fchg_q(field_begin), .err_q(sync_err)
    );

    vsd_pixel_gate #(.DATA_W(DATA_W)) gate_i (
        .clk(clk), .rst(rst), .byte_en(byte_en), .byte_in(byte_in),
        .ctrl_byte(ctrl_byte), .h_q(h_q), .v_q(vblank),
        .stb_q(pix_stb), .data_q(pix_byte)
    );
endmodule

// File: rtl/vsd_decoder_chk.sv
module vsd_decoder_chk (
    input logic clk,
    input logic rst,
    input logic byte_en,
    input logic ctrl_byte,
    input logic acquired,
    input logic pix_stb,
    input logic act_begin,
    input logic act_end,
    input logic field_begin,
    input logic vblank,
    input logic field_id,
    input logic sync_err
);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !byte_en |=> !pix_stb && !act_begin && !act_end && !field_begin && !sync_err);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !byte_en |=> $stable(vblank) && $stable(field_id));

    a_r2_err_keeps_state: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> $stable(vblank) && $stable(field_id));

    a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
        field_begin |-> (field_id != $past(field_id)));

    a_r7_change_has_pulse: assert property (@(posedge clk) disable iff (rst)
        (field_id != $past(field_id)) |-> field_begin);

    a_r3_one_edge: assert property (@(posedge clk) disable iff (rst)
        !(act_begin && act_end));

    a_r4_no_pix_in_vblank: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> !vblank);

    a_r5_ctrl_not_pixel: assert property (@(posedge clk) disable iff (rst)
        ctrl_byte |=> !pix_stb);

    a_r6_begin_keeps_v: assert property (@(posedge clk) disable iff (rst)
        (act_begin && $past(acquired)) |-> $stable(vblank));
endmodule

bind vsd_decoder vsd_decoder_chk chk_i (
    .clk(clk), .rst(rst), .byte_en(byte_en), .ctrl_byte(ctrl_byte),
    .acquired(acquired), .pix_stb(pix_stb), .act_begin(act_begin),
    .act_end(act_end), .field_begin(field_begin), .vblank(vblank),
    .field_id(field_id), .sync_err(sync_err)
);

// File: tb/vsd_decoder_tb_top.sv
module vsd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_en = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       pix_stb, act_begin, act_end, field_begin, vblank, field_id, sync_err;
    logic [7:0] pix_byte;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    vsd_decoder dut_i (
        .clk(clk), .rst(rst), .byte_en(byte_en), .byte_in(byte_in),
        .pix_stb(pix_stb), .pix_byte(pix_byte), .act_begin(act_begin),
        .act_end(act_end), .field_begin(field_begin), .vblank(vblank),
        .field_id(field_id), .sync_err(sync_err)
    );

    // Entry: {en, byte, expected {pix_stb, act_begin, act_end, field_begin, vblank, field_id, sync_err}}
    // Status bytes: 80=F0V0H0, 9D=F0V0H1, AB=F0V1H0, B6=F0V1H1, C7=F1V0H0, DA=F1V0H1, F1=F1V1H1 (R1, R2)
    localparam int NV = 56;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 8'hFF, 7'b0000100}, {1'b1, 8'h00, 7'b0000100}, {1'b1, 8'h00, 7'b0000100},
        {1'b1, 8'h9D, 7'b0000000},                                  // R9 first word sets V
        {1'b1, 8'h10, 7'b0000000},                                  // blanking byte, R9
        {1'b1, 8'hFF, 7'b0000000}, {1'b1, 8'h00, 7'b0000000}, {1'b1, 8'h00, 7'b0000000},
        {1'b1, 8'h80, 7'b0100000},                                  // R3 begin
        {1'b1, 8'h55, 7'b1000000}, {1'b1, 8'h66, 7'b1000000},       // R4
        {1'b0, 8'h77, 7'b0000000},                                  // R8 disabled
        {1'b1, 8'hFF, 7'b0000000}, {1'b1, 8'h00, 7'b0000000}, {1'b1, 8'h00, 7'b0000000}, // R5
        {1'b1, 8'h9D, 7'b0010000},                                  // R3 end
        {1'b1, 8'h10, 7'b0000000},
        {1'b1, 8'hFF, 7'b0000000}, {1'b1, 8'h00, 7'b0000000}, {1'b1, 8'h00, 7'b0000000},
        {1'b1, 8'hAB, 7'b0100000},                                  // R6 V in begin word ignored
        {1'b1, 8'h20, 7'b1000000},
        {1'b1, 8'hFF, 7'b0000000}, {1'b1, 8'h00, 7'b0000000}, {1'b1, 8'h00, 7'b0000000},
        {1'b1, 8'hB6, 7'b0010100},                                  // R6 V taken in end word
        {1'b1, 8'hFF, 7'b0000100}, {1'b1, 8'h00, 7'b0000100}, {1'b1, 8'h00, 7'b0000100},
        {1'b1, 8'hAB, 7'b0100100},
        {1'b1, 8'h30, 7'b0000100},                                  // R4 no strobe in vblank
        {1'b1, 8'hFF, 7'b0000100}, {1'b1, 8'h00, 7'b0000100}, {1'b1, 8'h00, 7'b0000100},
        {1'b1, 8'hF1, 7'b0011110},                                  // R7 field to 1
        {1'b1, 8'hFF, 7'b0000110}, {1'b1, 8'h00, 7'b0000110}, {1'b1, 8'h00, 7'b0000110},
        {1'b1, 8'hC0, 7'b0000111},                                  // R2 bad protection
        {1'b1, 8'h10, 7'b0000110},
        {1'b1, 8'hFF, 7'b0000110}, {1'b1, 8'h00, 7'b0000110}, {1'b1, 8'h00, 7'b0000110},
        {1'b1, 8'hDA, 7'b0000010},                                  // R3 no change of H, no pulse
        {1'b1, 8'hFF, 7'b0000010}, {1'b1, 8'h00, 7'b0000010}, {1'b1, 8'h00, 7'b0000010},
        {1'b1, 8'hC7, 7'b0100010},
        {1'b1, 8'h40, 7'b1000010},
        {1'b1, 8'hFF, 7'b0000010}, {1'b1, 8'h00, 7'b0000010}, {1'b1, 8'h00, 7'b0000010},
        {1'b1, 8'h9D, 7'b0011000},                                  // R7 field back to 0
        {1'b1, 8'hFF, 7'b0000000}, {1'b1, 8'h00, 7'b0000000},
        {1'b1, 8'h5A, 7'b0000000}                                   // R1 broken preamble
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_outs(input string tag, input logic [6:0] exp);
        logic [6:0] got;
        got = {pix_stb, act_begin, act_end, field_begin, vblank, field_id, sync_err};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: outputs got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic check_data(input string tag, input logic [7:0] exp);
        checks++;
        if (pix_byte !== exp) begin
            errors++;
            $display("FAIL %s: pix_byte got=%h expected=%h", tag, pix_byte, exp);
        end
    endtask

    task automatic send(input logic en, input logic [7:0] b);
        @(negedge clk);
        byte_en = en;
        byte_in = b;
        @(posedge clk);
        #2;
    endtask

    task automatic send_word(input logic [7:0] status);
        send(1'b1, 8'hFF);
        send(1'b1, 8'h00);
        send(1'b1, 8'h00);
        send(1'b1, status);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_outs("R9 reset state", 7'b0000100);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][15], VEC[i][14:7]);
            check_outs($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7 R8 R9)", i), VEC[i][6:0]);
            if (VEC[i][6]) check_data($sformatf("R4 vector %0d data", i), VEC[i][14:7]);
        end

        // R9: reset in the middle of an active line
        send_word(8'h80);
        send(1'b1, 8'h44);
        check_outs("R4 active before reset", 7'b1000000);
        @(negedge clk);
        rst = 1'b1;
        byte_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        check_outs("R9 mid-line reset", 7'b0000100);
        @(negedge clk);
        rst = 1'b0;
        send(1'b1, 8'h55);
        check_outs("R9 no strobe before begin word", 7'b0000100);
        send_word(8'hAB);
        check_outs("R9 first word after reset sets V", 7'b0100100);
        send(1'b1, 8'h11);
        check_outs("R9 vblank line not strobed", 7'b0000100);
        send_word(8'h9D);
        check_outs("R6 end word clears V", 7'b0010000);
        send_word(8'h80);
        check_outs("R3 begin after reacquire", 7'b0100000);
        send(1'b1, 8'h22);
        check_outs("R4 strobe after reacquire", 7'b1000000);
        check_data("R4 data after reacquire", 8'h22);

        // R2: zero marker bit is an error, state kept (still active)
        send_word(8'h00);
        check_outs("R2 zero marker", 7'b0000001);
        send(1'b1, 8'h33);
        check_outs("R2 state kept after bad word", 7'b1000000);

        // R5: lone 0x00 inside active video following FF is not strobed
        send(1'b1, 8'hFF);
        check_outs("R5 ff in active", 7'b0000000);
        send(1'b1, 8'h00);
        check_outs("R5 partial preamble zero", 7'b0000000);
        send(1'b1, 8'h3C);
        check_outs("R5 search abandoned, pixel resumes", 7'b1000000);

        send(1'b0, 8'h00);
        finish_run();
    end
endmodule